// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the byte-wide register interface of a serial port. A host reaches it over a simple memory-mapped bus with a 6-bit offset, one-cycle read and write strobes, and a byte of data each way. It holds the two mode registers, the transmitter and receiver enable flags, the transmit holding byte and the transmit-side status bits. It also decodes the packed command byte that drives the port's reset, enable and disable actions.

Written transmit bytes go to a downstream serializer through a one-cycle valid strobe. A separate receive FIFO and interrupt block attaches through level and strobe signals. This block reports the FIFO's ready and full levels in its status byte and forwards the FIFO's head byte on reads. It raises a pop strobe when the host reads received data, a flush strobe when the receiver is reset, and a clear strobe for the break-change flag. It also holds the interrupt mask that the interrupt block uses. Line timing, baud generation, parity and break generation are handled elsewhere.

Top module: `uart_regfront`

## Requirements
- R1: All six offset bits are decoded. Offsets not listed below read as 0x00, and writes to them change no register, enable or output. This includes 0x04, 0x10 and 0x18 written.
- R2: A write at offset 0x00 stores into the mode register chosen by a pointer, then moves the pointer to the second register, where it stays. A read at 0x00 returns the selected register. Mode register k drives `mode_bits[8k+7:8k]`.
- R3: A command byte written at offset 0x08 carries a misc field in bits 6:4, a transmitter field in bits 3:2 and a receiver field in bits 1:0. All three fields act on the same write, in the order misc, transmitter, receiver. A later field overrides an earlier one.
- R4: Misc code 1 returns the mode pointer to the first register. Misc code 5 gives a one-cycle `brk_clr` pulse in the write cycle. Misc codes 0, 4, 6 and 7 change nothing.
- R5: Misc code 2 disables the receiver and gives a one-cycle `rx_flush` pulse in the write cycle. Misc code 3 disables the transmitter and discards any pending byte, so the transmit-empty bit reads 1.
- R6: In both the transmitter field and the receiver field, code 1 enables, code 2 disables, and codes 0 and 3 leave the enable unchanged. The enables appear on `tx_enable` and `rx_enable` one cycle after the write.
- R7: A status read at offset 0x04 returns: bit 0 = `rx_ready`, bit 1 = `rx_full`, bit 2 = transmitter enable (transmit-ready), bit 3 = transmit-empty. Bits 7:4 read as 0.
- R8: A byte written at offset 0x0C while the transmitter is enabled appears on `tx_data` with `tx_valid` high for exactly the next cycle. Transmit-empty stays 1.
- R9: A byte written at 0x0C while the transmitter is disabled is held, and transmit-empty reads 0. A later write replaces the held byte. The held byte is sent the cycle after a command enables the transmitter, and transmit-empty then reads 1 again.
- R10: After reset, both mode registers are 0, the pointer selects the first one, both enables are 0, transmit-empty is 1, the mask is 0 and `tx_valid` is low.
- R11: A read at 0x0C returns `rx_head` when `rx_ready` is 1 and 0x00 otherwise. It raises `rx_pop` in the same cycle. No other read raises any strobe, and `bus_rdata` is 0x00 when `bus_rd` is low.
- R12: A write at 0x14 sets `irq_mask`. A read at 0x14 returns `irq_status`. Reads at 0x18 and 0x1C return `baud_div_a` and `baud_div_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| rx_ready | input | 1 | Receive FIFO holds data |
| rx_full | input | 1 | Receive FIFO is full |
| rx_head | input | 8 | Receive FIFO head byte |
| irq_status | input | 8 | Interrupt status byte from the interrupt block |
| baud_div_a | input | 8 | First baud divisor byte |
| baud_div_b | input | 8 | Second baud divisor byte |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_flush | output | 1 | Flush strobe to the receive FIFO |
| rx_enable | output | 1 | Receiver enable |
| brk_clr | output | 1 | Clear strobe for the break-change flag |
| irq_mask | output | 8 | Interrupt mask |
| mode_bits | output | 16 | Both mode registers, first in the low byte |
| tx_enable | output | 1 | Transmitter enable |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |

## Verification
The hardest case to reach is a command byte whose fields conflict with each other and with a pending transmit byte. One example is a transmitter reset together with a transmitter enable while a byte waits. The correct result is an enabled transmitter, no strobe, and an empty buffer. The stimulus sets this up deliberately: it disables the transmitter, writes a byte so that one is pending, then issues the combined command. It does the same on the receive side, pairing a receiver reset with an enable in one byte. A cycle-level model in the bench predicts every output on every clock, so any wrong ordering of the fields shows up at once.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam logic [5:0] OFS_MODE   = 6'h00;
  localparam logic [5:0] OFS_STAT   = 6'h04;
  localparam logic [5:0] OFS_CMD    = 6'h08;
  localparam logic [5:0] OFS_DATA   = 6'h0C;
  localparam logic [5:0] OFS_IRQ    = 6'h14;
  localparam logic [5:0] OFS_DIV_A  = 6'h18;
  localparam logic [5:0] OFS_DIV_B  = 6'h1C;

  typedef struct packed {
    logic ptr_rst;
    logic rx_reset;
    logic tx_reset;
    logic brk_clear;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;

  // Split a command byte into its actions; misc bits 6:4, tx 3:2, rx 1:0.
  function automatic cmd_act_t decode_cmd(input logic [7:0] c);
    cmd_act_t a;
    a.ptr_rst   = (c[6:4] == 3'd1);
    a.rx_reset  = (c[6:4] == 3'd2);
    a.tx_reset  = (c[6:4] == 3'd3);
    a.brk_clear = (c[6:4] == 3'd5);
    a.tx_on     = (c[3:2] == 2'd1);
    a.tx_off    = (c[3:2] == 2'd2);
    a.rx_on     = (c[1:0] == 2'd1);
    a.rx_off    = (c[1:0] == 2'd2);
    return a;
  endfunction

  function automatic logic [7:0] pack_status(input logic rdy, input logic full,
                                             input logic txrdy, input logic txemp);
    return {4'b0000, txemp, txrdy, full, rdy};
  endfunction

endpackage

// File: rtl/uart_rf_mode_bank.sv
module uart_rf_mode_bank #(
  parameter int DW    = 8,
  parameter int NMODE = 2,
  localparam int PW   = (NMODE > 1) ? $clog2(NMODE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DW-1:0]       wr_data,
  input  logic                ptr_rst,
  output logic [PW-1:0]       ptr,
  output logic [DW-1:0]       sel_data,
  output logic [NMODE*DW-1:0] regs_flat
);

  localparam logic [PW-1:0] LAST = PW'(NMODE - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_en) begin
      ptr <= (ptr == LAST) ? ptr : ptr + 1'b1;
    end else if (ptr_rst) begin
      ptr <= '0;
    end
  end

  for (genvar i = 0; i < NMODE; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_flat[i*DW +: DW] <= '0;
      end else if (wr_en && (ptr == PW'(i))) begin
        regs_flat[i*DW +: DW] <= wr_data;
      end
    end
  end

  always_comb begin
    sel_data = '0;
    for (int k = 0; k < NMODE; k++) begin
      if (ptr == PW'(k)) sel_data = regs_flat[k*DW +: DW];
    end
  end

endmodule

// File: rtl/uart_rf_tx_ctrl.sv
module uart_rf_tx_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_data,
  input  logic          tx_reset,
  input  logic          tx_on,
  input  logic          tx_off,
  output logic          tx_en,
  output logic          tx_empty,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);

  logic [DW-1:0] hold_q;
  logic          en_mid, emp_mid, en_nxt, emp_nxt, send_hold, send_new;

  // Misc reset applies first, then the transmitter field.
  always_comb begin
    en_mid    = tx_reset ? 1'b0 : tx_en;
    emp_mid   = tx_reset ? 1'b1 : tx_empty;
    en_nxt    = tx_on ? 1'b1 : (tx_off ? 1'b0 : en_mid);
    send_hold = tx_on && !emp_mid;
    send_new  = buf_wr && tx_en;
    emp_nxt   = emp_mid;
    if (send_hold)            emp_nxt = 1'b1;
    if (buf_wr && !tx_en)     emp_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      tx_empty <= 1'b1;
      hold_q   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_en    <= en_nxt;
      tx_empty <= emp_nxt;
      tx_valid <= send_hold || send_new;
      if (buf_wr) hold_q <= buf_data;
      if (send_new)       tx_data <= buf_data;
      else if (send_hold) tx_data <= hold_q;
    end
  end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 6,
  parameter int NMODE = 2,
  localparam int PW   = (NMODE > 1) ? $clog2(NMODE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic                rx_ready,
  input  logic                rx_full,
  input  logic [DW-1:0]       rx_head,
  input  logic [DW-1:0]       irq_status,
  input  logic [DW-1:0]       baud_div_a,
  input  logic [DW-1:0]       baud_div_b,
  output logic                rx_pop,
  output logic                rx_flush,
  output logic                rx_enable,
  output logic                brk_clr,
  output logic [DW-1:0]       irq_mask,
  output logic [NMODE*DW-1:0] mode_bits,
  output logic                tx_enable,
  output logic                tx_valid,
  output logic [DW-1:0]       tx_data
);

  // Named internal events
  logic          mode_wr, cmd_wr, buf_wr, mask_wr, data_rd;
  logic [PW-1:0] mode_ptr;
  logic [DW-1:0] mode_sel;
  logic          tx_empty;
  cmd_act_t      act;

  assign mode_wr = bus_wr && (bus_addr == AW'(OFS_MODE));
  assign cmd_wr  = bus_wr && (bus_addr == AW'(OFS_CMD));
  assign buf_wr  = bus_wr && (bus_addr == AW'(OFS_DATA));
  assign mask_wr = bus_wr && (bus_addr == AW'(OFS_IRQ));
  assign data_rd = bus_rd && (bus_addr == AW'(OFS_DATA));

  always_comb begin
    act = decode_cmd(8'(bus_wdata));
    if (!cmd_wr) act = '0;
  end

  assign rx_pop   = data_rd;
  assign rx_flush = act.rx_reset;
  assign brk_clr  = act.brk_clear;

  uart_rf_mode_bank #(.DW(DW), .NMODE(NMODE)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (mode_wr),
    .wr_data   (bus_wdata),
    .ptr_rst   (act.ptr_rst),
    .ptr       (mode_ptr),
    .sel_data  (mode_sel),
    .regs_flat (mode_bits)
  );

  uart_rf_tx_ctrl #(.DW(DW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .buf_wr   (buf_wr),
    .buf_data (bus_wdata),
    .tx_reset (act.tx_reset),
    .tx_on    (act.tx_on),
    .tx_off   (act.tx_off),
    .tx_en    (tx_enable),
    .tx_empty (tx_empty),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  // Receiver enable: misc reset first, receiver field last.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_enable <= 1'b0;
    end else if (act.rx_on) begin
      rx_enable <= 1'b1;
    end else if (act.rx_off || act.rx_reset) begin
      rx_enable <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_mask <= '0;
    else if (mask_wr) irq_mask <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        AW'(OFS_MODE):  bus_rdata = mode_sel;
        AW'(OFS_STAT):  bus_rdata = DW'(pack_status(rx_ready, rx_full, tx_enable, tx_empty));
        AW'(OFS_DATA):  bus_rdata = rx_ready ? rx_head : '0;
        AW'(OFS_IRQ):   bus_rdata = irq_status;
        AW'(OFS_DIV_A): bus_rdata = baud_div_a;
        AW'(OFS_DIV_B): bus_rdata = baud_div_b;
        default:        bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int PW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          rx_pop,
  input logic          rx_enable,
  input logic          tx_enable,
  input logic          tx_valid,
  input logic          tx_empty,
  input logic [PW-1:0] mode_ptr
);

  // R2
  mode_ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6'h00)) |=> (mode_ptr != '0));

  // R6
  tx_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6'h08) && bus_wdata[3:2] == 2'd1) |=> tx_enable);

  // R5
  rx_reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6'h08) && bus_wdata[6:4] == 3'd2 && bus_wdata[1:0] != 2'd1)
      |=> !rx_enable);

  // R8
  tx_strobe_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_enable && tx_empty));

  // R9
  pending_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_enable) && !$past(tx_empty) && $past(bus_wr && bus_addr == AW'(6'h08)
      && bus_wdata[6:4] != 3'd3)) |-> tx_valid);

  // R11
  pop_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> bus_rd);

  // R7
  status_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(6'h04)) |-> (bus_rdata[7:4] == 4'h0));

  // R11
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

endmodule

bind uart_regfront uart_regfront_chk #(.DW(DW), .AW(AW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rx_pop    (rx_pop),
  .rx_enable (rx_enable),
  .tx_enable (tx_enable),
  .tx_valid  (tx_valid),
  .tx_empty  (tx_empty),
  .mode_ptr  (mode_ptr)
);

// File: tb/sim_uart_regfront.sv
`timescale 1ns/1ps
module sim_uart_regfront;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        rx_ready = 1'b0, rx_full = 1'b0;
  logic [7:0]  rx_head = 8'h00, irq_status = 8'h00;
  logic [7:0]  baud_div_a = 8'h12, baud_div_b = 8'h34;
  logic        rx_pop, rx_flush, rx_enable, brk_clr, tx_enable, tx_valid;
  logic [7:0]  irq_mask, tx_data;
  logic [15:0] mode_bits;

  always #2 clk = ~clk;

  uart_regfront u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  byte unsigned m_mode[2];
  int           m_ptr;
  bit           m_txen, m_rxen, m_txemp, m_txv;
  byte unsigned m_tb, m_txd, m_mask;
  string        last_tag = "R10";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    chk(tag, "mode_bits", int'(mode_bits), int'({m_mode[1], m_mode[0]}));
    chk(tag, "tx_enable", int'(tx_enable), int'(m_txen));
    chk(tag, "rx_enable", int'(rx_enable), int'(m_rxen));
    chk(tag, "irq_mask", int'(irq_mask), int'(m_mask));
    chk(tag, "tx_valid", int'(tx_valid), int'(m_txv));
    if (m_txv) chk(tag, "tx_data", int'(tx_data), int'(m_txd));
  endtask

  function automatic int exp_rdata(bit rd, int a);
    if (!rd) return 0;
    case (a)
      'h00: return m_mode[m_ptr];
      'h04: return (int'(m_txemp) << 3) | (int'(m_txen) << 2) | (int'(rx_full) << 1) | int'(rx_ready);
      'h0C: return rx_ready ? int'(rx_head) : 0;
      'h14: return int'(irq_status);
      'h18: return int'(baud_div_a);
      'h1C: return int'(baud_div_b);
      default: return 0;
    endcase
  endfunction

  task automatic model_update(bit wr, int a, byte unsigned d);
    int misc, tf, rf;
    m_txv = 0;
    if (!wr) return;
    if (a == 'h00) begin
      m_mode[m_ptr] = d; m_ptr = 1;
    end else if (a == 'h08) begin
      misc = (d >> 4) & 7; tf = (d >> 2) & 3; rf = d & 3;
      if (misc == 1) m_ptr = 0;
      if (misc == 2) m_rxen = 0;
      if (misc == 3) begin m_txen = 0; m_txemp = 1; end
      if (tf == 1) begin
        m_txen = 1;
        if (!m_txemp) begin m_txv = 1; m_txd = m_tb; m_txemp = 1; end
      end
      if (tf == 2) m_txen = 0;
      if (rf == 1) m_rxen = 1;
      if (rf == 2) m_rxen = 0;
    end else if (a == 'h0C) begin
      m_tb = d;
      if (m_txen) begin m_txv = 1; m_txd = d; end
      else m_txemp = 0;
    end else if (a == 'h14) begin
      m_mask = d;
    end
  endtask

  task automatic step(string tag, bit wr, bit rd, int a, byte unsigned d);
    int misc;
    @(negedge clk);
    check_regs(last_tag);
    bus_wr = wr; bus_rd = rd; bus_addr = 6'(a); bus_wdata = d;
    #1;
    misc = (d >> 4) & 7;
    chk(tag, "bus_rdata", int'(bus_rdata), exp_rdata(rd, a));
    chk(tag, "rx_pop", int'(rx_pop), int'(rd && a == 'h0C));
    chk(tag, "rx_flush", int'(rx_flush), int'(wr && a == 'h08 && misc == 2));
    chk(tag, "brk_clr", int'(brk_clr), int'(wr && a == 'h08 && misc == 5));
    @(posedge clk);
    model_update(wr, a, d);
    last_tag = tag;
  endtask

  task automatic wr(string tag, int a, byte unsigned d); step(tag, 1, 0, a, d); endtask
  task automatic rd(string tag, int a); step(tag, 0, 1, a, 8'h00); endtask
  task automatic idle(string tag); step(tag, 0, 0, 0, 8'h00); endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_mode[0] = 0; m_mode[1] = 0; m_ptr = 0;
    m_txen = 0; m_rxen = 0; m_txemp = 1; m_txv = 0;
    m_tb = 0; m_txd = 0; m_mask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10 reset state, status and mode read
    rd("R10", 'h04);
    rd("R10", 'h00);

    // R1 unmapped offsets read zero, writes ignored
    rd("R1", 'h01); rd("R1", 'h3C); rd("R1", 'h10);
    wr("R1", 'h04, 8'hFF); wr("R1", 'h10, 8'hFF); wr("R1", 'h18, 8'hFF);
    wr("R1", 'h3D, 8'h05); idle("R1"); rd("R1", 'h04);

    // R2 mode pointer
    wr("R2", 'h00, 8'h11); rd("R2", 'h00);
    wr("R2", 'h00, 8'h22); wr("R2", 'h00, 8'h33); rd("R2", 'h00);
    // R4 pointer reset, break clear, no-op codes
    wr("R4", 'h08, 8'h10); rd("R4", 'h00);
    wr("R4", 'h08, 8'h50); wr("R4", 'h08, 8'h00); wr("R4", 'h08, 8'h40);
    wr("R4", 'h08, 8'h60); wr("R4", 'h08, 8'h70); rd("R4", 'h04);

    // R6 enable, reserved, disable
    wr("R6", 'h08, 8'h05); wr("R6", 'h08, 8'h0F); rd("R6", 'h04);
    wr("R6", 'h08, 8'h0A); rd("R6", 'h04);

    // R9 pending byte, overwrite, release on enable
    wr("R9", 'h0C, 8'hA5); rd("R9", 'h04);
    wr("R9", 'h0C, 8'h5A); wr("R9", 'h08, 8'h04); idle("R9"); rd("R9", 'h04);

    // R8 immediate sends, back to back
    wr("R8", 'h0C, 8'h3C); wr("R8", 'h0C, 8'hC3); idle("R8"); rd("R8", 'h04);

    // R3 misc reset then tx enable drops the pending byte
    wr("R3", 'h08, 8'h08); wr("R3", 'h0C, 8'h77); rd("R3", 'h04);
    wr("R3", 'h08, 8'h34); idle("R3"); rd("R3", 'h04);
    // R5 tx reset while enabled, rx reset with rx enable, plain rx reset
    wr("R5", 'h08, 8'h30); rd("R5", 'h04);
    wr("R3", 'h08, 8'h21); idle("R3");
    wr("R5", 'h08, 8'h20); idle("R5");

    // R7 status with FIFO levels
    rx_ready = 1; rx_full = 1; rd("R7", 'h04);
    rx_full = 0; rd("R7", 'h04);

    // R11 receive data reads
    rx_head = 8'h9E; rd("R11", 'h0C);
    rx_ready = 0; rd("R11", 'h0C);
    rd("R11", 'h1C);

    // R12 mask and read-only bytes
    irq_status = 8'h86;
    wr("R12", 'h14, 8'h83); rd("R12", 'h14); rd("R12", 'h18); rd("R12", 'h1C);
    idle("R12"); idle("R12");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule